// File: doc/BRIEF.md
# Burst and Communication Window Scheduler

This block alternates a sensing front end between acquisition bursts and quiet periods in which a host may move bytes over a serial link. It drives a host-facing ready line as a drive-low enable. When the enable is low the pin is released, and an external pull-up reads it high. The line is pulled low whenever a transfer must not begin. A periodic timeslot tick asks for a burst. The acquisition engine reports the end of a burst with a done flag. The serial shifter reports a byte in flight with a busy flag.

After every burst the scheduler holds the line low for a short settling time. It then releases the line for a minimum communication window. A burst that is due only launches once that window has run its full length. When the window closes, the line drops and a short grace period follows before the burst begins. A host that started a byte just as the line fell is still served. A byte that is in flight when the burst falls due postpones the burst until the byte completes, and no further bytes are admitted. Ticks that arrive during a long burst are remembered. Such an overrun burst is still followed by settling and a complete window. All times are counted in clock cycles and set by parameters.

Top module: `burst_window_sched`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ready_drive_low` and `burst_start` are 0. Reset also discards any pending burst request, so an idle window that follows reset stays released indefinitely.
- R2: `ready_drive_low` is 1 from the cycle the window closes, through the grace phase, any deferral, the whole burst and exactly SETTLE_CYC cycles after the cycle in which `burst_done` is sampled high. At all other times it is 0.
- R3: Each communication window keeps `ready_drive_low` at 0 for at least WIN_CYC consecutive cycles. After that, the window closes in the first cycle a burst is due, and it stays open for as long as none is due.
- R4: A `slot_tick` pulse in any phase makes a burst due. Any number of ticks before a launch produce exactly one burst. A tick that arrives during a burst makes another burst due, which starts only after settling and a full window.
- R5: If `xfer_busy` stays 0, `ready_drive_low` is 1 for exactly GRACE_CYC cycles before the cycle in which `burst_start` is 1.
- R6: If `xfer_busy` is 1 when the window would close or during the grace phase, the burst is held back until `xfer_busy` is sampled 0 and at least GRACE_CYC cycles have passed since the line dropped. `ready_drive_low` stays 1 while the burst is held back.
- R7: `burst_done` has no effect outside a burst. `xfer_busy` has no effect on an open window before a burst is due, and none during a burst or settling.
- R8: `burst_start` is a single-cycle pulse, one per launched burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | Periodic request for an acquisition burst |
| burst_done | input | 1 | Acquisition engine reports end of burst |
| xfer_busy | input | 1 | Serial interface has a byte in flight |
| burst_start | output | 1 | One-cycle strobe launching an acquisition burst |
| ready_drive_low | output | 1 | 1 pulls the host ready line low, 0 releases it |

## Verification
The bench builds the scheduler with a 6-cycle window, 2 settling cycles and a 3-cycle grace period. With these values a whole burst, settle and window round fits in about twenty cycles, so every edge of each phase can be checked cycle by cycle. The short grace period means a deferral can end either before or after the grace count has expired, which tests both ways back to the burst. Window saturation, collapse of several ticks into one request, and overrun ticks during a burst are all reached within a few dozen cycles.

// File: rtl/bws_pkg.sv
package bws_pkg;

    typedef enum logic [2:0] {
        PH_WINDOW = 3'd0,
        PH_GRACE  = 3'd1,
        PH_DEFER  = 3'd2,
        PH_BURST  = 3'd3,
        PH_SETTLE = 3'd4
    } phase_e;

    typedef struct packed {
        logic cnt_clr;
        logic consume;
        logic start;
    } fsm_ctl_t;

    function automatic int unsigned max_of3(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned top_val);
        return (top_val < 2) ? 1 : $clog2(top_val + 1);
    endfunction

endpackage

// File: rtl/bws_pending.sv
module bws_pending (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic consume,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)          pend <= 1'b0;
        else if (consume) pend <= 1'b0;
        else if (tick)    pend <= 1'b1;
    end
endmodule

// File: rtl/bws_counter.sv
module bws_counter #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr)          cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/bws_fsm.sv
module bws_fsm
    import bws_pkg::*;
#(
    parameter int unsigned WIN_CYC    = 250,
    parameter int unsigned SETTLE_CYC = 20,
    parameter int unsigned GRACE_CYC  = 10,
    parameter int unsigned CW         = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          due,
    input  logic          burst_done,
    input  logic          xfer_busy,
    input  logic [CW-1:0] cnt,
    output phase_e        phase,
    output fsm_ctl_t      ctl,
    output logic          start_q
);
    localparam logic [CW-1:0] WIN_LAST    = CW'(WIN_CYC - 1);
    localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
    localparam logic [CW-1:0] GRACE_LAST  = CW'(GRACE_CYC - 1);

    phase_e nxt;

    always_comb begin
        nxt = phase;
        ctl = '0;
        unique case (phase)
            PH_WINDOW: begin
                if (cnt >= WIN_LAST && due) begin
                    ctl.cnt_clr = 1'b1;
                    nxt = xfer_busy ? PH_DEFER : PH_GRACE;
                end
            end
            PH_GRACE: begin
                if (xfer_busy) begin
                    nxt = PH_DEFER;
                end else if (cnt >= GRACE_LAST) begin
                    nxt         = PH_BURST;
                    ctl.start   = 1'b1;
                    ctl.consume = 1'b1;
                end
            end
            PH_DEFER: begin
                if (!xfer_busy) begin
                    if (cnt >= GRACE_LAST) begin
                        nxt         = PH_BURST;
                        ctl.start   = 1'b1;
                        ctl.consume = 1'b1;
                    end else begin
                        nxt = PH_GRACE;
                    end
                end
            end
            PH_BURST: begin
                if (burst_done) begin
                    nxt = PH_SETTLE;
                    ctl.cnt_clr = 1'b1;
                end
            end
            PH_SETTLE: begin
                if (cnt >= SETTLE_LAST) begin
                    nxt = PH_WINDOW;
                    ctl.cnt_clr = 1'b1;
                end
            end
            default: begin
                nxt = PH_WINDOW;
                ctl.cnt_clr = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_WINDOW;
            start_q <= 1'b0;
        end else begin
            phase   <= nxt;
            start_q <= ctl.start;
        end
    end
endmodule

// File: rtl/burst_window_sched.sv
module burst_window_sched
    import bws_pkg::*;
#(
    parameter int unsigned WIN_CYC    = 250,
    parameter int unsigned SETTLE_CYC = 20,
    parameter int unsigned GRACE_CYC  = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic slot_tick,
    input  logic burst_done,
    input  logic xfer_busy,
    output logic burst_start,
    output logic ready_drive_low
);
    localparam int unsigned CNT_TOP = max_of3(WIN_CYC, SETTLE_CYC, GRACE_CYC);
    localparam int unsigned CW      = cnt_width(CNT_TOP);

    logic          pend;
    logic          due;
    logic [CW-1:0] cnt;
    phase_e        phase;
    fsm_ctl_t      ctl;

    assign due = pend | slot_tick;

    bws_pending u_pending (
        .clk     (clk),
        .rst     (rst),
        .tick    (slot_tick),
        .consume (ctl.consume),
        .pend    (pend)
    );

    bws_counter #(.CW(CW)) u_counter (
        .clk (clk),
        .rst (rst),
        .clr (ctl.cnt_clr),
        .cnt (cnt)
    );

    bws_fsm #(
        .WIN_CYC    (WIN_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .GRACE_CYC  (GRACE_CYC),
        .CW         (CW)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .due        (due),
        .burst_done (burst_done),
        .xfer_busy  (xfer_busy),
        .cnt        (cnt),
        .phase      (phase),
        .ctl        (ctl),
        .start_q    (burst_start)
    );

    assign ready_drive_low = (phase != PH_WINDOW);
endmodule

// File: rtl/bws_checker.sv
module bws_checker #(
    parameter int unsigned WIN_CYC   = 250,
    parameter int unsigned GRACE_CYC = 10
) (
    input logic clk,
    input logic rst,
    input logic xfer_busy,
    input logic burst_start,
    input logic ready_drive_low
);
    logic [15:0] rel_cnt;
    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rel_cnt <= '0;
            low_cnt <= '0;
        end else begin
            if (ready_drive_low) begin
                rel_cnt <= '0;
                if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
            end else begin
                low_cnt <= '0;
                if (rel_cnt != 16'hFFFF) rel_cnt <= rel_cnt + 1'b1;
            end
        end
    end

    assert_start_while_low_R2: assert property (@(posedge clk) disable iff (rst)
        burst_start |-> ready_drive_low);

    assert_low_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        burst_start |=> ready_drive_low);

    assert_window_min_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_drive_low) |-> (rel_cnt >= 16'(WIN_CYC)));

    assert_grace_before_start_R5: assert property (@(posedge clk) disable iff (rst)
        burst_start |-> (low_cnt >= 16'(GRACE_CYC)));

    assert_idle_link_at_start_R6: assert property (@(posedge clk) disable iff (rst)
        burst_start |-> !$past(xfer_busy));

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        burst_start |=> !burst_start);
endmodule

bind burst_window_sched bws_checker #(
    .WIN_CYC   (WIN_CYC),
    .GRACE_CYC (GRACE_CYC)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .xfer_busy       (xfer_busy),
    .burst_start     (burst_start),
    .ready_drive_low (ready_drive_low)
);

// File: tb/burst_window_sched_tb.sv
module burst_window_sched_tb;
    localparam int unsigned P_WIN    = 6;
    localparam int unsigned P_SETTLE = 2;
    localparam int unsigned P_GRACE  = 3;
    localparam int NV = 58;

    // bits: {slot_tick, burst_done, xfer_busy, exp_start, exp_low}
    localparam logic [4:0] VEC [NV] = '{
        5'b10000, 5'b00000, 5'b00000, 5'b00000, 5'b00000,  // 0-4 window, tick (R4)
        5'b00001, 5'b00001, 5'b00001, 5'b00011, 5'b00001,  // 5-9 grace then launch (R5)
        5'b01001, 5'b00001, 5'b00000, 5'b10000, 5'b00000,  // 10-14 settle, window (R2)
        5'b00000, 5'b00000, 5'b00100, 5'b00101, 5'b00101,  // 15-19 busy defers (R6, R7)
        5'b00101, 5'b00101, 5'b00011, 5'b10001, 5'b01001,  // 20-24 launch, overrun tick (R4)
        5'b00001, 5'b00000, 5'b00000, 5'b00000, 5'b00000,  // 25-29
        5'b00000, 5'b00000, 5'b00001, 5'b00101, 5'b00001,  // 30-34 busy in grace (R6)
        5'b00011, 5'b01001, 5'b00001, 5'b10000, 5'b00000,  // 35-39 tick in settle
        5'b10000, 5'b00000, 5'b00000, 5'b00000, 5'b00001,  // 40-44 second tick collapses
        5'b00001, 5'b00001, 5'b00011, 5'b01001, 5'b00001,  // 45-49
        5'b00000, 5'b00000, 5'b00000, 5'b00000, 5'b00000,  // 50-54 no second burst
        5'b00000, 5'b00000, 5'b00000                       // 55-57
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic slot_tick = 1'b0;
    logic burst_done = 1'b0;
    logic xfer_busy = 1'b0;
    logic burst_start;
    logic ready_drive_low;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    burst_window_sched #(
        .WIN_CYC    (P_WIN),
        .SETTLE_CYC (P_SETTLE),
        .GRACE_CYC  (P_GRACE)
    ) u_dut (
        .clk             (clk),
        .rst             (rst),
        .slot_tick       (slot_tick),
        .burst_done      (burst_done),
        .xfer_busy       (xfer_busy),
        .burst_start     (burst_start),
        .ready_drive_low (ready_drive_low)
    );

    task automatic check_outs(input logic es, input logic el, input string tag);
        n_checks++;
        if (burst_start !== es) begin
            n_errors++;
            $display("FAIL %s burst_start got %0b expected %0b at %0t", tag, burst_start, es, $time);
        end
        n_checks++;
        if (ready_drive_low !== el) begin
            n_errors++;
            $display("FAIL %s ready_drive_low got %0b expected %0b at %0t", tag, ready_drive_low, el, $time);
        end
    endtask

    task automatic cyc(input logic t, input logic d, input logic b,
                       input logic es, input logic el, input string tag);
        slot_tick  = t;
        burst_done = d;
        xfer_busy  = b;
        @(negedge clk);
        check_outs(es, el, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_outs(1'b0, 1'b0, "R1 in reset");
        rst = 1'b0;
        check_outs(1'b0, 1'b0, "R1 after reset");

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0],
                "R2 R3 R4 R5 R6 R8 table");
        end

        // R7: done during an open window changes nothing
        cyc(0, 1, 0, 0, 0, "R7 done in window");
        // R3: saturated window closes on the tick itself
        cyc(1, 0, 0, 0, 1, "R3 close on tick");
        cyc(0, 0, 0, 0, 1, "R5 grace");
        cyc(0, 0, 0, 0, 1, "R5 grace");
        cyc(0, 0, 0, 1, 1, "R5 launch");
        // R7: busy during burst and settle has no effect
        cyc(0, 0, 1, 0, 1, "R8 R7 busy in burst");
        cyc(0, 0, 1, 0, 1, "R7 busy in burst");
        cyc(0, 1, 1, 0, 1, "R7 done with busy");
        cyc(0, 0, 1, 0, 1, "R2 settle");
        cyc(0, 0, 1, 0, 0, "R7 busy ignored at release");
        // reach grace, then reset discards the pending request
        cyc(1, 0, 0, 0, 0, "R4 tick in window");
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, "R3 window hold");
        cyc(0, 0, 0, 0, 1, "R3 window close");
        rst = 1'b1;
        @(negedge clk);
        check_outs(1'b0, 1'b0, "R1 mid-cycle reset");
        rst = 1'b0;
        for (int k = 0; k < 8; k++) cyc(0, 0, 0, 0, 0, "R1 pending cleared");

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_errors++;
        $display("FAIL watchdog expired, got hang expected completion");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule